// File: doc/BRIEF.md
# Dual-die flash command select filter

Two identical flash dies share one chip select, one serial clock and one data-in line inside a package. Both dies decode every command frame. This block is the front end of one die. A strap input tells the die whether it owns the low or the high half of the package address space. For every command that carries a 4-byte address, the die compares address bit 26 with its strap. It claims the command only when the two agree. Otherwise it drops the rest of the frame and leaves its data output undriven.

The serial interface reaches the block as synchronous samples. `bit_en_i` is a one-cycle strobe for each serial clock edge, and `mosi_i` carries the bit that goes with it. Opcode and address are shifted in MSB first. The claimed die handles the following commands:
- 4-byte read, which auto-increments the address within its own half.
- Register access by index, for reading and for writing.
- Whole-die erase.
- Suspend and resume of program/erase.

The legacy bulk erase without an address is rejected by both dies. The flash array is a stub whose contents are computed from the address.

Top module: `fdsel_die_filter`

## Requirements
- R1: After reset `so_oe_o` and `so_o` are 0, the register file entries 1 to 7 read 0, and the suspend and erased flags are 0.
- R2: Each frame starts with the opcode, shifted in MSB first on `bit_en_i` strobes. Raising `cs_n_i` ends the frame at any bit. The next frame decodes a fresh opcode.
- R3: The die claims an addressed command (opcodes 13h, 65h, 71h, FEh, 85h, 75h, 7Ah, 8Ah) only when address bit 26 equals `strap_high_i`. An unclaimed command never asserts `so_oe_o` during its frame and changes no die state.
- R4: Read (13h) returns one byte per 8 strobes, MSB first on `so_o`. The byte for die address a is a[7:0] XOR a[25:18], or FFh once the die is erased. The first bit appears right after the strobe that carries the last address bit.
- R5: The read address increments in 26 bits. After 3FFFFFFh it continues at 0000000h of the same half.
- R6: Write-register (71h) stores each data byte into entry addr[2:0] for indexes 1 to 7. A write to index 0 has no effect.
- R7: Read-register (65h) repeats entry addr[2:0] in every data byte. Index 0 is status: bit 7 = strap, bit 1 = erased, bit 0 = suspended, all other bits 0.
- R8: Legacy bulk erase (60h or C7h) is rejected. It never drives `so_o` and leaves the erased flag and the array contents unchanged.
- R9: Addressed erase (FEh) sets the erased flag of the claimed die only.
- R10: Suspend (85h or 75h) sets the suspended flag and resume (7Ah or 8Ah) clears it, each only on the claimed die.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_high_i | input | 1 | 1 marks this die as the high-address half |
| cs_n_i | input | 1 | Shared chip select, active low |
| bit_en_i | input | 1 | One-cycle strobe per serial bit |
| mosi_i | input | 1 | Serial data in, sampled with `bit_en_i` |
| so_o | output | 1 | Serial data out, 0 when not driven |
| so_oe_o | output | 1 | Output enable for `so_o` |

## Verification
The first data bit of a read is due one clock after the strobe that carries address bit 0. Each later bit is due one strobe after the previous one. The bench reads `so_o` and `so_oe_o` on the falling edge just before it raises each strobe. Writes, erase and suspend/resume only become visible in a later frame, so the bench confirms them with a register or array read in that next frame. Every address is swept with bit 26 both matching and not matching the strap, under both strap values.

// File: rtl/fdsel_pkg.sv
package fdsel_pkg;

  typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DATA, PH_SKIP} phase_e;

  localparam logic [7:0] OPC_READ4      = 8'h13;
  localparam logic [7:0] OPC_RDREG      = 8'h65;
  localparam logic [7:0] OPC_WRREG      = 8'h71;
  localparam logic [7:0] OPC_ERASE_DIE  = 8'hFE;
  localparam logic [7:0] OPC_SUSP_A     = 8'h85;
  localparam logic [7:0] OPC_SUSP_B     = 8'h75;
  localparam logic [7:0] OPC_RESM_A     = 8'h7A;
  localparam logic [7:0] OPC_RESM_B     = 8'h8A;
  localparam logic [7:0] OPC_LEG_ERA_A  = 8'h60;
  localparam logic [7:0] OPC_LEG_ERA_B  = 8'hC7;

  function automatic logic op_is_susp(input logic [7:0] op);
    return (op == OPC_SUSP_A) || (op == OPC_SUSP_B);
  endfunction

  function automatic logic op_is_resume(input logic [7:0] op);
    return (op == OPC_RESM_A) || (op == OPC_RESM_B);
  endfunction

  function automatic logic op_takes_addr(input logic [7:0] op);
    return (op == OPC_READ4) || (op == OPC_RDREG) || (op == OPC_WRREG) ||
           (op == OPC_ERASE_DIE) || op_is_susp(op) || op_is_resume(op);
  endfunction

  function automatic logic op_has_data(input logic [7:0] op);
    return (op == OPC_READ4) || (op == OPC_RDREG) || (op == OPC_WRREG);
  endfunction

  function automatic logic op_is_legacy_erase(input logic [7:0] op);
    return (op == OPC_LEG_ERA_A) || (op == OPC_LEG_ERA_B);
  endfunction

endpackage

// File: rtl/fdsel_frame.sv
module fdsel_frame
  import fdsel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIE_AW = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              bit_en_i,
  input  logic              mosi_i,
  input  logic              strap_i,
  output logic [7:0]        op_o,
  output logic              hit_o,
  output logic [DIE_AW-1:0] hit_addr_o,
  output logic              data_step_o,
  output logic              byte_end_o,
  output logic [7:0]        rx_byte_o
);

  localparam int CNT_W = $clog2(ADDR_W);

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]  sh_q, sh_d;
  logic [7:0]         op_q, op_d;
  logic               sh_en;
  logic               hit, data_step, byte_end;

  always_comb begin
    sh_d      = {sh_q[ADDR_W-2:0], mosi_i};
    sh_en     = !cs_n_i && bit_en_i;
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    op_d      = op_q;
    hit       = 1'b0;
    data_step = 1'b0;
    byte_end  = 1'b0;
    if (cs_n_i) begin
      phase_d = PH_OP;
      cnt_d   = '0;
    end else if (bit_en_i) begin
      case (phase_q)
        PH_OP: begin
          if (cnt_q == CNT_W'(7)) begin
            op_d    = sh_d[7:0];
            cnt_d   = '0;
            phase_d = op_takes_addr(sh_d[7:0]) ? PH_ADDR : PH_SKIP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_ADDR: begin
          if (cnt_q == CNT_W'(ADDR_W-1)) begin
            cnt_d = '0;
            if (sh_d[DIE_AW] == strap_i) begin
              hit     = 1'b1;
              phase_d = op_has_data(op_q) ? PH_DATA : PH_SKIP;
            end else begin
              phase_d = PH_SKIP;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          data_step = 1'b1;
          byte_end  = (cnt_q[2:0] == 3'd7);
          cnt_d     = byte_end ? '0 : cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OP;
      cnt_q   <= '0;
      op_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign op_o        = op_q;
  assign hit_o       = hit;
  assign hit_addr_o  = sh_d[DIE_AW-1:0];
  assign data_step_o = data_step;
  assign byte_end_o  = byte_end;
  assign rx_byte_o   = sh_d[7:0];

  // R2: a deselected bus always leaves the decoder at the first opcode bit
  assert_frame_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (phase_q == PH_OP && cnt_q == '0));

  // R8: a completed legacy erase opcode drops the rest of the frame
  assert_legacy_erase_skipped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && bit_en_i && phase_q == PH_OP && cnt_q == CNT_W'(7) &&
     op_is_legacy_erase(sh_d[7:0])) |=> (phase_q == PH_SKIP));

endmodule

// File: rtl/fdsel_regs.sv
module fdsel_regs
  import fdsel_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strap_i,
  input  logic [7:0]              op_i,
  input  logic                    hit_i,
  input  logic [$clog2(NREG)-1:0] hit_idx_i,
  input  logic                    byte_end_i,
  input  logic [7:0]              rx_byte_i,
  input  logic [$clog2(NREG)-1:0] rd_idx_i,
  output logic [7:0]              rd_data_o,
  output logic                    erased_o
);

  localparam int IDX_W = $clog2(NREG);

  logic [IDX_W-1:0] wr_idx_q, wr_idx_d;
  logic             susp_q, susp_d;
  logic             erased_q, erased_d;
  logic             wr_en;
  logic [7:0]       rd_vec [NREG];

  always_comb begin
    wr_idx_d = wr_idx_q;
    susp_d   = susp_q;
    erased_d = erased_q;
    if (hit_i) begin
      wr_idx_d = hit_idx_i;
      if (op_i == OPC_ERASE_DIE) erased_d = 1'b1;
      if (op_is_susp(op_i))      susp_d   = 1'b1;
      if (op_is_resume(op_i))    susp_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      susp_q   <= 1'b0;
      erased_q <= 1'b0;
    end else begin
      wr_idx_q <= wr_idx_d;
      susp_q   <= susp_d;
      erased_q <= erased_d;
    end
  end

  assign wr_en     = byte_end_i && (op_i == OPC_WRREG);
  assign rd_vec[0] = {strap_i, 5'b0, erased_q, susp_q};

  for (genvar g = 1; g < NREG; g++) begin : g_entry
    logic [7:0] val_q;
    logic       we;
    assign we = wr_en && (wr_idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (we) begin
        val_q <= rx_byte_i;
      end
    end
    assign rd_vec[g] = val_q;
  end

  assign rd_data_o = rd_vec[rd_idx_i];
  assign erased_o  = erased_q;

  // R9: erase state is never undone
  assert_erase_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erased_q |=> erased_q);

  // R9: erase only follows a claimed addressed erase
  assert_erase_needs_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erased_q) |-> $past(hit_i && op_i == OPC_ERASE_DIE));

  // R10: suspend state moves only on a claimed command
  assert_susp_needs_claim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(susp_q) |-> $past(hit_i));

endmodule

// File: rtl/fdsel_out.sv
module fdsel_out
  import fdsel_pkg::*;
#(
  parameter int DIE_AW = 26,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic [7:0]        op_i,
  input  logic              hit_i,
  input  logic [DIE_AW-1:0] hit_addr_i,
  input  logic              data_step_i,
  input  logic              byte_end_i,
  input  logic              erased_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [7:0]        rd_data_i,
  output logic              so_o,
  output logic              so_oe_o
);

  logic [DIE_AW-1:0] ptr_q, ptr_d;
  logic [7:0]        osh_q, osh_d;
  logic              oe_q, oe_d;
  logic              regmode_q, regmode_d;
  logic [IDX_W-1:0]  ridx_q, ridx_d;
  logic              is_rd, is_rdreg;

  function automatic logic [7:0] stub_byte(input logic [DIE_AW-1:0] a, input logic er);
    return er ? 8'hFF : (a[7:0] ^ a[DIE_AW-1 -: 8]);
  endfunction

  assign is_rdreg = (op_i == OPC_RDREG);
  assign is_rd    = (op_i == OPC_READ4) || is_rdreg;
  assign rd_idx_o = hit_i ? hit_addr_i[IDX_W-1:0] : ridx_q;

  always_comb begin
    ptr_d     = ptr_q;
    osh_d     = osh_q;
    oe_d      = oe_q;
    regmode_d = regmode_q;
    ridx_d    = ridx_q;
    if (cs_n_i) begin
      oe_d = 1'b0;
    end else if (hit_i && is_rd) begin
      oe_d      = 1'b1;
      regmode_d = is_rdreg;
      ridx_d    = hit_addr_i[IDX_W-1:0];
      ptr_d     = hit_addr_i + 1'b1;
      osh_d     = is_rdreg ? rd_data_i : stub_byte(hit_addr_i, erased_i);
    end else if (data_step_i && oe_q) begin
      if (byte_end_i) begin
        if (regmode_q) begin
          osh_d = rd_data_i;
        end else begin
          osh_d = stub_byte(ptr_q, erased_i);
          ptr_d = ptr_q + 1'b1;
        end
      end else begin
        osh_d = {osh_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      osh_q     <= '0;
      oe_q      <= 1'b0;
      regmode_q <= 1'b0;
      ridx_q    <= '0;
    end else begin
      ptr_q     <= ptr_d;
      osh_q     <= osh_d;
      oe_q      <= oe_d;
      regmode_q <= regmode_d;
      ridx_q    <= ridx_d;
    end
  end

  assign so_o    = oe_q & osh_q[7];
  assign so_oe_o = oe_q;

  // R3: the output is enabled only right after this die claimed the command
  assert_drive_needs_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(hit_i));

  // R3: the output is released as soon as the frame ends
  assert_release_at_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> !oe_q);

  // R5: the read pointer wraps inside the die's half
  assert_ptr_wraps_in_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && !hit_i && data_step_i && byte_end_i && oe_q && !regmode_q && ptr_q == '1)
    |=> (ptr_q == '0));

endmodule

// File: rtl/fdsel_die_filter.sv
module fdsel_die_filter #(
  parameter int ADDR_W = 32,
  parameter int DIE_AW = 26,
  parameter int NREG   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_high_i,
  input  logic cs_n_i,
  input  logic bit_en_i,
  input  logic mosi_i,
  output logic so_o,
  output logic so_oe_o
);

  localparam int IDX_W = $clog2(NREG);

  logic              rst_m, rst_s;
  logic [7:0]        op;
  logic              hit, data_step, byte_end, erased;
  logic [DIE_AW-1:0] hit_addr;
  logic [7:0]        rx_byte, rd_data;
  logic [IDX_W-1:0]  rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  fdsel_frame #(.ADDR_W(ADDR_W), .DIE_AW(DIE_AW)) u_frame (
    .clk        (clk),
    .rst_n      (rst_s),
    .cs_n_i     (cs_n_i),
    .bit_en_i   (bit_en_i),
    .mosi_i     (mosi_i),
    .strap_i    (strap_high_i),
    .op_o       (op),
    .hit_o      (hit),
    .hit_addr_o (hit_addr),
    .data_step_o(data_step),
    .byte_end_o (byte_end),
    .rx_byte_o  (rx_byte)
  );

  fdsel_regs #(.NREG(NREG)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .strap_i   (strap_high_i),
    .op_i      (op),
    .hit_i     (hit),
    .hit_idx_i (hit_addr[IDX_W-1:0]),
    .byte_end_i(byte_end),
    .rx_byte_i (rx_byte),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .erased_o  (erased)
  );

  fdsel_out #(.DIE_AW(DIE_AW), .IDX_W(IDX_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_s),
    .cs_n_i     (cs_n_i),
    .op_i       (op),
    .hit_i      (hit),
    .hit_addr_i (hit_addr),
    .data_step_i(data_step),
    .byte_end_i (byte_end),
    .erased_i   (erased),
    .rd_idx_o   (rd_idx),
    .rd_data_i  (rd_data),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o)
  );

endmodule

// File: tb/fdsel_die_filter_tb.sv
`timescale 1ns/1ps
module fdsel_die_filter_tb;

  logic clk = 1'b0;
  logic rst_n, strap, cs_n, bit_en, mosi;
  logic so, so_oe;
  int   n_chk = 0;
  int   n_bad = 0;
  logic oe_seen;

  logic       m_erased, m_susp;
  logic [7:0] m_reg [8];

  always #2.5 clk = ~clk;

  fdsel_die_filter u_dut (
    .clk(clk), .rst_n(rst_n), .strap_high_i(strap), .cs_n_i(cs_n),
    .bit_en_i(bit_en), .mosi_i(mosi), .so_o(so), .so_oe_o(so_oe)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [25:0] a);
    return m_erased ? 8'hFF : (a[7:0] ^ a[25:18]);
  endfunction

  function automatic logic [7:0] status();
    return {strap, 5'b0, m_erased, m_susp};
  endfunction

  task automatic bit_x(input logic b, output logic s);
    s = so;
    oe_seen = oe_seen | so_oe;
    mosi = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic begin_frame();
    oe_seen = 1'b0;
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send8(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(v[i], s);
  endtask

  task automatic send32(input logic [31:0] v);
    logic s;
    for (int i = 31; i >= 0; i--) bit_x(v[i], s);
  endtask

  task automatic xfer(input logic [7:0] din, output logic [7:0] dout);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_x(din[i], s);
      dout[i] = s;
    end
  endtask

  task automatic read_check(input logic [31:0] a, input int nb, input string req);
    logic [7:0]  d;
    logic        sel;
    logic [25:0] p;
    sel = (a[26] == strap);
    p = a[25:0];
    begin_frame();
    send8(8'h13);
    send32(a);
    for (int k = 0; k < nb; k++) begin
      chk({req, " oe"}, 32'(so_oe), 32'(sel));
      xfer(8'h00, d);
      if (sel) chk({req, " data"}, 32'(d), 32'(pat(p)));
      p = p + 26'd1;
    end
    if (!sel) chk({req, " unclaimed stays undriven"}, 32'(oe_seen), 32'd0);
    end_frame();
  endtask

  task automatic rdreg_check(input logic [31:0] a, input string req);
    logic [7:0] d, e;
    logic       sel;
    sel = (a[26] == strap);
    e = (a[2:0] == 3'd0) ? status() : m_reg[a[2:0]];
    begin_frame();
    send8(8'h65);
    send32(a);
    for (int k = 0; k < 2; k++) begin
      xfer(8'h00, d);
      if (sel) chk({req, " reg read"}, 32'(d), 32'(e));
    end
    chk({req, " reg oe"}, 32'(oe_seen), 32'(sel));
    end_frame();
  endtask

  task automatic wrreg(input logic [31:0] a, input logic [7:0] v);
    logic [7:0] d;
    begin_frame();
    send8(8'h71);
    send32(a);
    xfer(v, d);
    end_frame();
    if (a[26] == strap && a[2:0] != 3'd0) m_reg[a[2:0]] = v;
  endtask

  task automatic cmd(input logic [7:0] op, input logic [31:0] a);
    begin_frame();
    send8(op);
    send32(a);
    end_frame();
    if (a[26] == strap) begin
      if (op == 8'hFE) m_erased = 1'b1;
      if (op == 8'h85 || op == 8'h75) m_susp = 1'b1;
      if (op == 8'h7A || op == 8'h8A) m_susp = 1'b0;
    end
  endtask

  function automatic logic [31:0] mk(input logic top, input logic [25:0] low);
    return {5'b0, top, low};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [25:0] lows [5];
    lows[0] = 26'h0000000; lows[1] = 26'h0123456; lows[2] = 26'h2ABCDEF;
    lows[3] = 26'h3FFFF00; lows[4] = 26'h15A5A5A;
    m_erased = 1'b0; m_susp = 1'b0;
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    rst_n = 1'b0; strap = 1'b0; cs_n = 1'b1; bit_en = 1'b0; mosi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 so_oe after reset", 32'(so_oe), 32'd0);
    chk("R1 so after reset", 32'(so), 32'd0);
    rdreg_check(mk(1'b0, 26'd0), "R1 R7 status");
    for (int i = 1; i < 8; i++) rdreg_check(mk(1'b0, 26'(i)), "R1 entry reset");

    // R3 R4: both straps, both halves, several addresses
    for (int st = 0; st < 2; st++) begin
      strap = st[0];
      @(negedge clk);
      for (int t = 0; t < 2; t++)
        for (int k = 0; k < 5; k++)
          read_check(mk(t[0], lows[k]), 3, "R3 R4 read");
      // R5 wrap inside the half
      read_check(mk(strap, 26'h3FFFFFE), 4, "R5 wrap");
      read_check(mk(~strap, 26'h3FFFFFE), 2, "R3 R5 other half");
    end
    strap = 1'b0;
    @(negedge clk);

    // R2 aborted frames
    begin_frame();
    for (int i = 0; i < 4; i++) begin logic s; bit_x(1'b1, s); end
    end_frame();
    read_check(mk(1'b0, 26'h0000A5C), 2, "R2 after opcode abort");
    begin_frame();
    send8(8'h13);
    for (int i = 0; i < 10; i++) begin logic s; bit_x(1'b1, s); end
    end_frame();
    read_check(mk(1'b0, 26'h1111111), 2, "R2 after address abort");

    // R6 R7 register file
    for (int i = 1; i < 8; i++) begin
      wrreg(mk(1'b1, 26'(i)), 8'(8'h80 + i));
      wrreg(mk(1'b0, 26'(i)), 8'(8'h30 ^ (i * 7)));
    end
    for (int i = 1; i < 8; i++) rdreg_check(mk(1'b0, 26'(i)), "R6 R7 entry");
    rdreg_check(mk(1'b1, 26'd3), "R3 R7 unclaimed reg read");
    wrreg(mk(1'b0, 26'd0), 8'hFF);
    rdreg_check(mk(1'b0, 26'd0), "R6 index 0 write ignored");

    // R10 suspend / resume
    cmd(8'h85, mk(1'b1, 26'd0));
    rdreg_check(mk(1'b0, 26'd0), "R10 unclaimed suspend");
    cmd(8'h85, mk(1'b0, 26'd0));
    rdreg_check(mk(1'b0, 26'd0), "R10 suspend 85");
    cmd(8'h7A, mk(1'b0, 26'd0));
    rdreg_check(mk(1'b0, 26'd0), "R10 resume 7A");
    cmd(8'h75, mk(1'b0, 26'd0));
    rdreg_check(mk(1'b0, 26'd0), "R10 suspend 75");
    cmd(8'h8A, mk(1'b1, 26'd0));
    rdreg_check(mk(1'b0, 26'd0), "R10 unclaimed resume");
    cmd(8'h8A, mk(1'b0, 26'd0));
    rdreg_check(mk(1'b0, 26'd0), "R10 resume 8A");

    // R8 legacy bulk erase rejected
    begin_frame();
    send8(8'h60);
    send32(32'h0);
    chk("R8 legacy 60 undriven", 32'(oe_seen), 32'd0);
    end_frame();
    begin_frame();
    send8(8'hC7);
    send32(32'h0);
    chk("R8 legacy C7 undriven", 32'(oe_seen), 32'd0);
    end_frame();
    rdreg_check(mk(1'b0, 26'd0), "R8 status after legacy erase");
    read_check(mk(1'b0, 26'h0234567), 2, "R8 array after legacy erase");

    // R9 addressed erase
    cmd(8'hFE, mk(1'b1, 26'd0));
    rdreg_check(mk(1'b0, 26'd0), "R9 unclaimed erase");
    read_check(mk(1'b0, 26'h0345678), 2, "R9 array after unclaimed erase");
    cmd(8'hFE, mk(1'b0, 26'd0));
    rdreg_check(mk(1'b0, 26'd0), "R9 erased status");
    read_check(mk(1'b0, 26'h0345678), 3, "R9 erased array");
    strap = 1'b1;
    @(negedge clk);
    rdreg_check(mk(1'b1, 26'd0), "R7 status strap high");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule